// File: doc/BRIEF.md
# Flash Status and Write-Protection Controller

This block keeps the eight-bit status word of a serial flash device and decides whether each write-type operation may proceed. A command decoder in front of it hands over single-cycle strobes for write-enable set and clear, status write, sector erase, chip erase, page program and software reset, together with the target address and the data byte of a status write. The block checks the write-enable latch, the block-protect range and the status-write lock. It then grants or refuses the operation, holds the device busy while the array works, and watches the operation against a cycle limit.

The array reports the end of an operation on a completion input. If that does not arrive within the limit for the operation type, the error flag rises and the device stays busy until a software reset. The protection fields are ordinary flops here; in silicon they would be backed by non-volatile cells. The status word is driven continuously, so it can be read at any time, including during an operation.

Top module: `flash_status_ctrl`

## Requirements
- R1: `status_o` carries busy in bit 0, write-enable in bit 1, the block-protect code in bits 4:2, the error flag in bit 5, a reserved zero in bit 6 and the status-write lock in bit 7. After reset it reads 00h.
- R2: While idle, `wren_i` sets the write-enable bit and `wrdis_i` clears it.
- R3: A status write, sector erase, chip erase or page program arriving while write-enable is 0 is refused, and the status word does not change.
- R4: Page program and sector erase are refused when `addr_i[18:16]` falls in the protected range. Code 0 protects nothing. Code 1 protects sector 7. Code 2 protects sectors 6 and 7. Code 3 protects sectors 4 to 7. Codes 4 to 7 protect all eight sectors.
- R5: Chip erase is granted only when the block-protect code is 0.
- R6: A status write is refused when bit 7 is 1 and `wp_n_i` is low. With `wp_n_i` high the lock has no effect.
- R7: A granted status write copies data bits 4:2 and 7 into the status word when it completes. Data bits 0, 1, 5 and 6 have no effect.
- R8: When `cell_done_i` arrives during a running operation, busy and write-enable both return to 0.
- R9: If an operation runs for its limit in cycles (sector erase `SE_LIMIT`, chip erase `CE_LIMIT`, program `PP_LIMIT`, status write `SW_LIMIT`) without completion, the error bit rises on that cycle and busy stays 1. A later `cell_done_i` changes nothing.
- R10: `swreset_i` clears busy, error and write-enable in the next cycle, whatever the state.
- R11: While busy, every strobe except `swreset_i` leaves the status word unchanged, and write-type strobes are refused.
- R12: `grant_o` or `reject_o` pulses for exactly one cycle, in the cycle after a write-type strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wren_i | input | 1 | Set-write-enable strobe |
| wrdis_i | input | 1 | Clear-write-enable strobe |
| stwr_i | input | 1 | Status write strobe |
| stwr_data_i | input | 8 | Data byte of a status write |
| sect_erase_i | input | 1 | Sector erase strobe |
| chip_erase_i | input | 1 | Chip erase strobe |
| prog_i | input | 1 | Page program strobe |
| swreset_i | input | 1 | Software reset strobe |
| wp_n_i | input | 1 | Write-protect pin, active low |
| addr_i | input | ADDR_W | Target byte address |
| cell_done_i | input | 1 | Array reports the running operation has finished |
| status_o | output | 8 | Status word |
| grant_o | output | 1 | Operation accepted (one-cycle pulse) |
| reject_o | output | 1 | Operation refused (one-cycle pulse) |

## Verification
Program and sector erase are tried at addresses just below and just above each protected boundary for codes 1, 2, 3 and 5. This separates an off-by-one-sector decode from a correct one. The status write is tried with the lock clear, with the lock set and the pin low, and with the lock set and the pin high. It is also tried with all data bits set, so that a leak into the read-only bits would show. A program whose completion never arrives is sampled one cycle before and at its limit, and is then hit with completion and enable strobes before a software reset. This tells a correct timeout apart from early or late timeouts and from a lock that something other than the reset can clear.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_SE   = 3'd1,
    OP_CE   = 3'd2,
    OP_PP   = 3'd3,
    OP_SW   = 3'd4
  } op_kind_e;

  localparam int unsigned ST_BUSY = 0;
  localparam int unsigned ST_WEL  = 1;
  localparam int unsigned ST_BP_L = 2;
  localparam int unsigned ST_ERR  = 5;
  localparam int unsigned ST_LOCK = 7;

endpackage

// File: rtl/flash_prot_map.sv
module flash_prot_map #(
  parameter int unsigned SECT_W = 3
) (
  input  logic [2:0]        bp_i,
  input  logic [SECT_W-1:0] sect_i,
  output logic              hit_o,
  output logic              none_o
);
  localparam int unsigned NSECT = 1 << SECT_W;

  logic [NSECT-1:0] mask;

  for (genvar s = 0; s < NSECT; s++) begin : g_sect
    always_comb begin
      if (bp_i[2])
        mask[s] = 1'b1;
      else if (bp_i == 3'd0)
        mask[s] = 1'b0;
      else
        mask[s] = (s >= int'(NSECT - (NSECT >> (4 - int'(bp_i)))));
    end
  end

  assign hit_o  = mask[sect_i];
  assign none_o = (bp_i == 3'd0);

endmodule

// File: rtl/flash_op_timer.sv
module flash_op_timer #(
  parameter int unsigned TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [TW-1:0] lim_i,
  input  logic          run_i,
  input  logic          done_i,
  input  logic          abort_i,
  output logic          expire_o
);
  logic [TW-1:0] cnt_q, cnt_d;
  logic [TW-1:0] lim_q, lim_d;
  logic          at_end;

  assign at_end   = (cnt_q == lim_q - TW'(1));
  assign expire_o = run_i && at_end && !done_i;

  always_comb begin
    cnt_d = cnt_q;
    lim_d = lim_q;
    if (abort_i) begin
      cnt_d = '0;
    end else if (start_i) begin
      cnt_d = '0;
      lim_d = lim_i;
    end else if (run_i && !done_i && !at_end) begin
      cnt_d = cnt_q + TW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= '1;
    end else begin
      cnt_q <= cnt_d;
      lim_q <= lim_d;
    end
  end

  // R9: the count never passes the limit of the running operation
  p_cnt_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt_q < lim_q));

endmodule

// File: rtl/flash_status_ctrl.sv
module flash_status_ctrl
  import flash_status_pkg::*;
#(
  parameter int unsigned ADDR_W   = 19,
  parameter int unsigned SECT_W   = 3,
  parameter int unsigned SE_LIMIT = 40,
  parameter int unsigned CE_LIMIT = 80,
  parameter int unsigned PP_LIMIT = 20,
  parameter int unsigned SW_LIMIT = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wren_i,
  input  logic              wrdis_i,
  input  logic              stwr_i,
  input  logic [7:0]        stwr_data_i,
  input  logic              sect_erase_i,
  input  logic              chip_erase_i,
  input  logic              prog_i,
  input  logic              swreset_i,
  input  logic              wp_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              cell_done_i,
  output logic [7:0]        status_o,
  output logic              grant_o,
  output logic              reject_o
);
  localparam int unsigned MAX_A = (SE_LIMIT > CE_LIMIT) ? SE_LIMIT : CE_LIMIT;
  localparam int unsigned MAX_B = (PP_LIMIT > SW_LIMIT) ? PP_LIMIT : SW_LIMIT;
  localparam int unsigned MAX_L = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned TW    = $clog2(MAX_L + 1);

  logic       busy_q, busy_d, wel_q, wel_d, err_q, err_d, lock_q, lock_d;
  logic [2:0] bp_q, bp_d, pbp_q, pbp_d;
  logic       plock_q, plock_d, grant_q, grant_d, reject_q, reject_d;
  op_kind_e   kind_q, kind_d, req_kind;
  logic       any_wr, req_ok, start, expire, prot_hit, prot_none;
  logic [TW-1:0] req_lim;

  assign any_wr = stwr_i || sect_erase_i || chip_erase_i || prog_i;

  flash_prot_map #(.SECT_W(SECT_W)) i_prot (
    .bp_i   (bp_q),
    .sect_i (addr_i[ADDR_W-1 -: SECT_W]),
    .hit_o  (prot_hit),
    .none_o (prot_none)
  );

  always_comb begin
    req_kind = OP_NONE;
    req_ok   = 1'b0;
    req_lim  = TW'(PP_LIMIT);
    if (sect_erase_i) begin
      req_kind = OP_SE; req_ok = !prot_hit;  req_lim = TW'(SE_LIMIT);
    end else if (chip_erase_i) begin
      req_kind = OP_CE; req_ok = prot_none;  req_lim = TW'(CE_LIMIT);
    end else if (prog_i) begin
      req_kind = OP_PP; req_ok = !prot_hit;  req_lim = TW'(PP_LIMIT);
    end else if (stwr_i) begin
      req_kind = OP_SW; req_ok = !(lock_q && !wp_n_i); req_lim = TW'(SW_LIMIT);
    end
  end

  flash_op_timer #(.TW(TW)) i_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start),
    .lim_i    (req_lim),
    .run_i    (busy_q && !err_q),
    .done_i   (cell_done_i),
    .abort_i  (swreset_i),
    .expire_o (expire)
  );

  always_comb begin
    busy_d = busy_q; wel_d = wel_q; err_d = err_q; lock_d = lock_q;
    bp_d = bp_q; pbp_d = pbp_q; plock_d = plock_q; kind_d = kind_q;
    grant_d = 1'b0; reject_d = 1'b0; start = 1'b0;
    if (swreset_i) begin
      busy_d = 1'b0; err_d = 1'b0; wel_d = 1'b0; kind_d = OP_NONE;
    end else if (busy_q) begin
      reject_d = any_wr;
      if (!err_q && cell_done_i) begin
        busy_d = 1'b0; wel_d = 1'b0; kind_d = OP_NONE;
        if (kind_q == OP_SW) begin
          bp_d = pbp_q; lock_d = plock_q;
        end
      end else if (expire) begin
        err_d = 1'b1;
      end
    end else if (any_wr) begin
      if (wel_q && req_ok) begin
        busy_d = 1'b1; kind_d = req_kind; grant_d = 1'b1; start = 1'b1;
        pbp_d = stwr_data_i[4:2]; plock_d = stwr_data_i[7];
      end else begin
        reject_d = 1'b1;
      end
    end else if (wren_i) begin
      wel_d = 1'b1;
    end else if (wrdis_i) begin
      wel_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; wel_q <= 1'b0; err_q <= 1'b0; lock_q <= 1'b0;
      bp_q <= '0; pbp_q <= '0; plock_q <= 1'b0; kind_q <= OP_NONE;
      grant_q <= 1'b0; reject_q <= 1'b0;
    end else begin
      busy_q <= busy_d; wel_q <= wel_d; err_q <= err_d; lock_q <= lock_d;
      bp_q <= bp_d; pbp_q <= pbp_d; plock_q <= plock_d; kind_q <= kind_d;
      grant_q <= grant_d; reject_q <= reject_d;
    end
  end

  assign status_o = {lock_q, 1'b0, err_q, bp_q, wel_q, busy_q};
  assign grant_o  = grant_q;
  assign reject_o = reject_q;

  // R9: error only exists while busy, and holds until software reset
  p_err_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> busy_q);
  p_err_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !swreset_i) |=> err_q);
  // R8: completion ends the operation and drops write-enable
  p_done_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !err_q && cell_done_i && !swreset_i) |=> (!busy_q && !wel_q));
  // R3: no grant without write-enable
  p_no_wel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (any_wr && !wel_q) |=> !grant_o);
  // R5: chip erase needs protect code zero
  p_chip_prot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_erase_i && bp_q != 3'd0) |=> !grant_o);
  // R6: locked status write is never granted
  p_sr_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stwr_i && lock_q && !wp_n_i && !sect_erase_i && !chip_erase_i && !prog_i)
      |=> !grant_o);
  // R10: software reset always leaves the device idle
  p_reset_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    swreset_i |=> (!busy_q && !err_q && !wel_q));
  // R12: grant and refusal never coincide
  p_one_answer_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant_o && reject_o));

endmodule

// File: tb/test_flash_status_ctrl.sv
module test_flash_status_ctrl;
  localparam int PP_LIM = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wren = 0, wrdis = 0, stwr = 0, se = 0, ce = 0, pp = 0, swr = 0;
  logic wp_n = 1, done = 0;
  logic [7:0]  sdata = 0;
  logic [18:0] addr = 0;
  logic [7:0]  status;
  logic        grant, reject;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  flash_status_ctrl #(.PP_LIMIT(PP_LIM)) i_flash_status_ctrl (
    .clk(clk), .rst_n(rst_n), .wren_i(wren), .wrdis_i(wrdis), .stwr_i(stwr),
    .stwr_data_i(sdata), .sect_erase_i(se), .chip_erase_i(ce), .prog_i(pp),
    .swreset_i(swr), .wp_n_i(wp_n), .addr_i(addr), .cell_done_i(done),
    .status_o(status), .grant_o(grant), .reject_o(reject)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // kind: 0 wren 1 wrdis 2 stwr 3 se 4 ce 5 pp 6 swreset 7 done
  task automatic issue(input int kind, input logic [7:0] d, input logic [18:0] a);
    @(negedge clk);
    sdata = d; addr = a;
    wren = (kind == 0); wrdis = (kind == 1); stwr = (kind == 2); se = (kind == 3);
    ce = (kind == 4); pp = (kind == 5); swr = (kind == 6); done = (kind == 7);
    @(negedge clk);
    wren = 0; wrdis = 0; stwr = 0; se = 0; ce = 0; pp = 0; swr = 0; done = 0;
  endtask

  task automatic try_op(input string req, input int kind, input logic [18:0] a,
                        input logic [7:0] d, input bit expect_grant);
    issue(kind, d, a);
    chk(req, {6'd0, grant, reject}, expect_grant ? 8'h02 : 8'h01);
    if (expect_grant) issue(7, 8'h00, 19'h0);
  endtask

  task automatic set_bp(input logic [2:0] code);
    issue(0, 0, 0);
    issue(2, {3'b000, code, 2'b00}, 0);
    issue(7, 0, 0);
    chk("R7", status, {3'b000, code, 2'b00});
  endtask

  task automatic t_reset;
    chk("R1", status, 8'h00);
    chk("R12", {6'd0, grant, reject}, 8'h00);
  endtask

  task automatic t_wel;
    issue(0, 0, 0); chk("R2", status, 8'h02);
    issue(1, 0, 0); chk("R2", status, 8'h00);
  endtask

  task automatic t_no_wel;
    issue(5, 8'h00, 19'h00000);
    chk("R3", {6'd0, grant, reject}, 8'h01);
    chk("R3", status, 8'h00);
  endtask

  task automatic t_program_done;
    issue(0, 0, 0);
    issue(5, 8'h00, 19'h12345);
    chk("R12", {6'd0, grant, reject}, 8'h02);
    chk("R8", status, 8'h03);
    issue(7, 0, 0);
    chk("R8", status, 8'h00);
  endtask

  task automatic t_status_write;
    issue(0, 0, 0);
    issue(2, 8'hFF, 0);
    chk("R7", status, 8'h03);
    issue(7, 0, 0);
    chk("R7", status, 8'h9C);
    issue(0, 0, 0);
    wp_n = 0;
    issue(2, 8'h04, 0);
    chk("R6", {6'd0, grant, reject}, 8'h01);
    chk("R6", status, 8'h9E);
    wp_n = 1;
    issue(2, 8'h04, 0);
    chk("R6", {6'd0, grant, reject}, 8'h02);
    issue(7, 0, 0);
    chk("R6", status, 8'h04);
  endtask

  task automatic t_ranges;
    issue(0, 0, 0);
    try_op("R4", 3, 19'h70000, 0, 0);
    try_op("R4", 3, 19'h6FFFF, 0, 1);
    issue(0, 0, 0);
    try_op("R5", 4, 19'h0, 0, 0);
    chk("R5", status, 8'h06);
    issue(1, 0, 0);
    set_bp(3'd2);
    issue(0, 0, 0); try_op("R4", 5, 19'h60000, 0, 0);
    try_op("R4", 5, 19'h5FFFF, 0, 1);
    set_bp(3'd3);
    issue(0, 0, 0); try_op("R4", 5, 19'h40000, 0, 0);
    try_op("R4", 3, 19'h3FFFF, 0, 1);
    set_bp(3'd5);
    issue(0, 0, 0); try_op("R4", 5, 19'h00000, 0, 0);
    issue(1, 0, 0);
    set_bp(3'd0);
    issue(0, 0, 0); try_op("R5", 4, 19'h0, 0, 1);
    chk("R8", status, 8'h00);
  endtask

  task automatic t_timeout;
    issue(0, 0, 0);
    issue(5, 0, 19'h00100);
    repeat (PP_LIM - 1) @(negedge clk);
    chk("R9", status, 8'h03);
    @(negedge clk);
    chk("R9", status, 8'h23);
    issue(7, 0, 0);
    chk("R9", status, 8'h23);
    issue(1, 0, 0);
    chk("R11", status, 8'h23);
    issue(2, 8'h9C, 0);
    chk("R11", {6'd0, grant, reject}, 8'h01);
    chk("R11", status, 8'h23);
    issue(6, 0, 0);
    chk("R10", status, 8'h00);
  endtask

  task automatic t_busy_ignore;
    issue(0, 0, 0);
    issue(4, 0, 0);
    issue(0, 0, 0);
    issue(5, 0, 19'h0);
    chk("R11", {6'd0, grant, reject}, 8'h01);
    chk("R11", status, 8'h03);
    issue(6, 0, 0);
    chk("R10", status, 8'h00);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_wel();
        t_no_wel();
        t_program_done();
        t_status_write();
        t_ranges();
        t_timeout();
        t_busy_ignore();
      end
      begin
        repeat (20000) @(negedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule